// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Macrocells

This block is a small field-configurable logic array. A programmable AND plane forms product terms from the data inputs and from signals fed back from the outputs. Each output then ORs a fixed group of these terms that belongs only to it. Each OR result passes through a macrocell. The macrocell holds a flip-flop copy of the OR result, picks either the direct result or that copy, and drives an output pin modelled as a data value plus an enable flag. The selected value of every macrocell returns to the AND plane, so the array can hold multi-level logic and registered state machines.

The configuration image is shifted in serially, one bit per rising clock edge, while `cfg_load` is high. A three-state controller sequences the load. In ST_RUN the array evaluates and the macrocell flip-flops update. In ST_SHIFT the image is being shifted and every pin is disabled. ST_APPLY is a single cycle in which the shifted image replaces the active one. The transitions are: RUN→SHIFT when load is high, SHIFT→SHIFT while load stays high, SHIFT→APPLY when load falls, APPLY→SHIFT if load is high again, and APPLY→RUN otherwise.

Top module: `pal_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the macrocell flip-flops, the shift register and the active image, and puts the controller in ST_RUN. Afterwards `pin_oe` and `pin_val` are all 0.
- R2: While `cfg_load` is high, each rising edge shifts in one bit from `cfg_din`. After MAP_BITS shifts, the k-th bit sent (counting from 0) is image bit k. MAP_BITS = N_OUT*N_PT*LITS + 2*N_OUT, where LITS = 2*(N_IN+N_OUT).
- R3: From the first rising edge that samples `cfg_load` high, every pin is disabled (`pin_oe`=0, `pin_val`=0). The first edge that samples `cfg_load` low enters ST_APPLY. The next edge installs the new image and returns to ST_RUN, and from then on the new image drives the pins.
- R4: Term t of output o uses image bits starting at (o*N_PT+t)*LITS. For literal j, bit 2j connects the true form and bit 2j+1 connects the complemented form. Literals j < N_IN are data input j, and literal N_IN+k is the feedback of output k. A term is the AND of its connected literals.
- R5: A term with no connected literal evaluates to 0.
- R6: The OR grouping is fixed: output o is the OR of its own N_PT terms and of no others.
- R7: Image bit AND_BITS+2o selects registered mode (1) or combinational mode (0) for output o, where AND_BITS = N_OUT*N_PT*LITS. Each flip-flop captures its OR result at every rising edge in ST_RUN, so a registered output shows that value one edge later.
- R8: Image bit AND_BITS+2o+1 enables pin o in ST_RUN. A disabled pin has `pin_oe`=0 and `pin_val`=0. An enabled pin has `pin_oe`=1 and shows the selected macrocell value.
- R9: The selected value of a registered output feeds every term. The selected value of a combinational output k feeds only the terms of outputs o > k. For any other output, a connected form of that literal forces the term to 0.
- R10: Macrocell flip-flops hold their value in ST_SHIFT and ST_APPLY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | High while the configuration image is being shifted |
| cfg_din | input | 1 | Serial configuration bit |
| din | input | N_IN | Data inputs to the AND plane |
| pin_val | output | N_OUT | Output pin data (0 when disabled) |
| pin_oe | output | N_OUT | Output pin enable |

## Verification
Combinational outputs follow `din` within the same cycle. The bench therefore drives inputs on the falling edge and samples one time unit later. A registered output reflects the inputs of a cycle only after the next rising edge, so the bench model advances its flip-flop copy right after each rising edge and compares in the following cycle. Pin enables drop at the first edge that samples `cfg_load` high, stay low through the apply cycle, and return two edges after `cfg_load` falls. The bench checks the disabled state in every one of those cycles. It also counts the edge that enters the load as a final update of the flip-flops.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/pal_cfg_ctrl.sv
module pal_cfg_ctrl
    import pal_pkg::*;
#(
    parameter int MAP_BITS = 392
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_load,
    input  logic                cfg_din,
    output logic [MAP_BITS-1:0] map_q,
    output logic                run
);
    cfg_state_e state, state_nx;
    logic [MAP_BITS-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   state_nx = cfg_load ? ST_SHIFT : ST_RUN;
            ST_SHIFT: state_nx = cfg_load ? ST_SHIFT : ST_APPLY;
            ST_APPLY: state_nx = cfg_load ? ST_SHIFT : ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        run = (state == ST_RUN);
    end

    // serial image: newest bit enters at the top, first bit ends at index 0
    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '0;
        else if (cfg_load) shift_q <= {cfg_din, shift_q[MAP_BITS-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst)                    map_q <= '0;
        else if (state == ST_APPLY) map_q <= shift_q;
    end

    p_load_enters_shift_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (state == ST_SHIFT));
    p_fall_enters_apply_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && !cfg_load) |=> (state == ST_APPLY));
    p_image_held_r3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_APPLY) |=> $stable(map_q));
endmodule

// File: rtl/pal_term_group.sv
module pal_term_group #(
    parameter int N_IN    = 8,
    parameter int N_OUT   = 4,
    parameter int N_PT    = 4,
    parameter int OUT_IDX = 0,
    localparam int NL     = N_IN + N_OUT,
    localparam int LITS   = 2 * NL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_IN-1:0]      din,
    input  logic [N_OUT-1:0]     fb_q,
    input  logic [N_OUT-1:0]     fb_lo,
    input  logic [N_OUT-1:0]     fb_regd,
    input  logic [N_PT*LITS-1:0] fuses,
    output logic                 or_out
);
    logic [NL-1:0]   lit_pos, lit_neg;
    logic [N_PT-1:0] term;

    for (genvar j = 0; j < N_IN; j++) begin : g_in
        assign lit_pos[j] = din[j];
        assign lit_neg[j] = ~din[j];
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_fb
        localparam logic LOWER = (k < OUT_IDX);
        logic ok, v;
        assign ok = fb_regd[k] | LOWER;
        assign v  = fb_regd[k] ? fb_q[k] : fb_lo[k];
        assign lit_pos[N_IN+k] = ok & v;
        assign lit_neg[N_IN+k] = ok & ~v;
    end

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [LITS-1:0] fz;
        logic [NL-1:0]   ft, fc;
        assign fz = fuses[t*LITS +: LITS];
        for (genvar j = 0; j < NL; j++) begin : g_split
            assign ft[j] = fz[2*j];
            assign fc[j] = fz[2*j+1];
        end
        assign term[t] = (|fz) & (&(~ft | lit_pos)) & (&(~fc | lit_neg));

        p_empty_term_low_r5: assert property (@(posedge clk) disable iff (rst)
            term[t] |-> (fz != '0));
    end

    assign or_out = |term;
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic or_in,
    input  logic reg_mode,
    input  logic oe_bit,
    output logic mc_val,
    output logic q_out,
    output logic pin_v,
    output logic pin_e
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)      q_r <= 1'b0;
        else if (run) q_r <= or_in;
    end

    always_comb begin
        mc_val = reg_mode ? q_r : or_in;
        q_out  = q_r;
        pin_e  = oe_bit & run;
        pin_v  = pin_e & mc_val;
    end

    p_hold_while_loading_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(q_r));
endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 4,
    parameter int N_PT  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] pin_val,
    output logic [N_OUT-1:0] pin_oe
);
    localparam int LITS      = 2 * (N_IN + N_OUT);
    localparam int TERM_BITS = N_PT * LITS;
    localparam int AND_BITS  = N_OUT * TERM_BITS;
    localparam int MAP_BITS  = AND_BITS + 2 * N_OUT;

    logic [MAP_BITS-1:0] map_q;
    logic                run;
    logic [N_OUT-1:0]    q_all, regd;

    pal_cfg_ctrl #(.MAP_BITS(MAP_BITS)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_din(cfg_din),
        .map_q(map_q), .run(run)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_mode
        assign regd[o] = map_q[AND_BITS + 2*o];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic             or_r, mc_v, q_r, pv, pe;
        logic [N_OUT-1:0] lo_in;

        if (o == 0) begin : g_first
            assign lo_in = '0;
        end else begin : g_next
            assign lo_in = g_out[o-1].lo_in
                         | ({{(N_OUT-1){1'b0}}, g_out[o-1].mc_v} << (o-1));
        end

        pal_term_group #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT), .OUT_IDX(o)) u_terms (
            .clk(clk), .rst(rst), .din(din), .fb_q(q_all), .fb_lo(lo_in),
            .fb_regd(regd), .fuses(map_q[o*TERM_BITS +: TERM_BITS]), .or_out(or_r)
        );

        pal_macrocell u_mc (
            .clk(clk), .rst(rst), .run(run), .or_in(or_r),
            .reg_mode(map_q[AND_BITS + 2*o]), .oe_bit(map_q[AND_BITS + 2*o + 1]),
            .mc_val(mc_v), .q_out(q_r), .pin_v(pv), .pin_e(pe)
        );

        assign q_all[o]   = q_r;
        assign pin_val[o] = pv;
        assign pin_oe[o]  = pe;
    end

    p_pins_off_in_load_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (pin_oe == '0 && pin_val == '0));
endmodule

// File: tb/sim_pal_array.sv
module sim_pal_array;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 8;
    localparam int N_OUT = 4;
    localparam int N_PT  = 4;
    localparam int NL    = N_IN + N_OUT;
    localparam int LITS  = 2 * NL;
    localparam int AND_BITS = N_OUT * N_PT * LITS;
    localparam int MAP_BITS = AND_BITS + 2 * N_OUT;

    logic clk = 1'b0;
    logic rst, cfg_load, cfg_din;
    logic [N_IN-1:0]  din;
    logic [N_OUT-1:0] pin_val, pin_oe;

    int checks = 0;
    int fails  = 0;
    logic [MAP_BITS-1:0] m_map;
    logic [N_OUT-1:0]    m_q, m_or, m_mx, seen_val, seen_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)) u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_din(cfg_din),
        .din(din), .pin_val(pin_val), .pin_oe(pin_oe)
    );

    function automatic void model_eval(input logic [MAP_BITS-1:0] m, input logic [N_IN-1:0] d,
                                       input logic [N_OUT-1:0] q,
                                       output logic [N_OUT-1:0] orr, output logic [N_OUT-1:0] mx);
        orr = '0;
        mx  = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int t = 0; t < N_PT; t++) begin
                int base;
                bit any, prod;
                base = (o*N_PT + t) * LITS;
                any  = 1'b0;
                prod = 1'b1;
                for (int j = 0; j < NL; j++) begin
                    bit v, ok;
                    if (j < N_IN) begin
                        v = d[j]; ok = 1'b1;
                    end else if (m[AND_BITS + 2*(j-N_IN)]) begin
                        v = q[j-N_IN]; ok = 1'b1;
                    end else if ((j-N_IN) < o) begin
                        v = mx[j-N_IN]; ok = 1'b1;
                    end else begin
                        v = 1'b0; ok = 1'b0;
                    end
                    if (m[base + 2*j])     begin any = 1'b1; if (!(ok && v))  prod = 1'b0; end
                    if (m[base + 2*j + 1]) begin any = 1'b1; if (!(ok && !v)) prod = 1'b0; end
                end
                if (any && prod) orr[o] = 1'b1;
            end
            mx[o] = m[AND_BITS + 2*o] ? q[o] : orr[o];
        end
    endfunction

    function automatic logic [MAP_BITS-1:0] put_lit(input logic [MAP_BITS-1:0] m, input int o,
                                                    input int t, input int j, input bit comp);
        m[(o*N_PT + t)*LITS + 2*j + int'(comp)] = 1'b1;
        return m;
    endfunction

    function automatic logic [MAP_BITS-1:0] put_mode(input logic [MAP_BITS-1:0] m, input int o,
                                                     input bit regd, input bit oe);
        m[AND_BITS + 2*o]     = regd;
        m[AND_BITS + 2*o + 1] = oe;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        logic [N_OUT-1:0] eoe, ev;
        model_eval(m_map, din, m_q, m_or, m_mx);
        for (int o = 0; o < N_OUT; o++) eoe[o] = m_map[AND_BITS + 2*o + 1];
        ev = m_mx & eoe;
        chk(pin_oe == eoe, req, 32'(pin_oe), 32'(eoe));
        chk(pin_val == ev, req, 32'(pin_val), 32'(ev));
        seen_val = pin_val;
        seen_oe  = pin_oe;
    endtask

    task automatic run_cycle(input logic [N_IN-1:0] v, input string req);
        @(negedge clk);
        din = v;
        #1;
        check_model(req);
        @(posedge clk);
        m_q = m_or;
    endtask

    task automatic load_map(input logic [MAP_BITS-1:0] img);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_din  = img[0];
        #1;
        check_model("R8 before load");
        @(posedge clk);
        m_q = m_or;                       // entry edge still runs the flip-flops
        for (int k = 1; k < MAP_BITS; k++) begin
            @(negedge clk);
            cfg_din = img[k];
            #1;
            chk(pin_oe == '0 && pin_val == '0, "R3 pins off while shifting",
                {pin_oe, pin_val}, 32'h0);
        end
        @(negedge clk);
        cfg_load = 1'b0;
        #1;
        chk(pin_oe == '0 && pin_val == '0, "R3 pins off last shift", {pin_oe, pin_val}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(pin_oe == '0 && pin_val == '0, "R3 pins off in apply", {pin_oe, pin_val}, 32'h0);
        @(posedge clk);
        m_map = img;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [MAP_BITS-1:0] img;
        logic [1:0] cnt, prev;
        void'($urandom(32'd4711));
        rst = 1'b1; cfg_load = 1'b0; cfg_din = 1'b0; din = '0;
        m_map = '0; m_q = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pin_oe == '0 && pin_val == '0, "R1 reset pins", {pin_oe, pin_val}, 32'h0);

        // two-bit counter on outputs 2 (low) and 3 (high), registered feedback
        img = '0;
        img = put_mode(img, 2, 1'b1, 1'b1);
        img = put_mode(img, 3, 1'b1, 1'b1);
        img = put_lit(img, 2, 0, N_IN+2, 1'b1);
        img = put_lit(img, 3, 0, N_IN+3, 1'b0);
        img = put_lit(img, 3, 0, N_IN+2, 1'b1);
        img = put_lit(img, 3, 1, N_IN+3, 1'b1);
        img = put_lit(img, 3, 1, N_IN+2, 1'b0);
        load_map(img);
        prev = 2'd0;
        for (int i = 0; i < 9; i++) begin
            run_cycle(N_IN'($urandom), "R7 counter model");
            cnt = {seen_val[3], seen_val[2]};
            if (i == 0) chk(cnt == 2'd0, "R1 counter starts cleared", 32'(cnt), 32'h0);
            else        chk(cnt == prev + 2'd1, "R7 counter increments", 32'(cnt), 32'(prev + 2'd1));
            prev = cnt;
        end
        load_map(img);
        run_cycle(N_IN'($urandom), "R10 after reload");
        cnt = {seen_val[3], seen_val[2]};
        chk(cnt == prev + 2'd2, "R10 count frozen during load", 32'(cnt), 32'(prev + 2'd2));

        // XOR on output 0; empty enabled output 1; disabled output 3
        img = '0;
        img = put_mode(img, 0, 1'b0, 1'b1);
        img = put_lit(img, 0, 0, 0, 1'b0);
        img = put_lit(img, 0, 0, 1, 1'b1);
        img = put_lit(img, 0, 1, 0, 1'b1);
        img = put_lit(img, 0, 1, 1, 1'b0);
        img = put_mode(img, 1, 1'b0, 1'b1);
        img = put_mode(img, 3, 1'b0, 1'b0);
        img = put_lit(img, 3, 0, 0, 1'b0);
        load_map(img);
        for (int r = 0; r < 8; r++) begin
            logic [N_IN-1:0] v;
            v = (N_IN'($urandom) & ~N_IN'(3)) | N_IN'(r % 4);
            run_cycle(v, "R2 R4 R6 xor model");
            chk(seen_val[0] == (v[0] ^ v[1]), "R4 R6 xor value", 32'(seen_val[0]), 32'(v[0] ^ v[1]));
            chk(seen_oe[1] && !seen_val[1], "R5 empty terms low", {seen_oe[1], seen_val[1]}, 32'h2);
            chk(!seen_oe[3] && !seen_val[3], "R8 disabled pin", {seen_oe[3], seen_val[3]}, 32'h0);
        end

        // combinational feedback ordering
        img = '0;
        for (int o = 0; o < N_OUT; o++) img = put_mode(img, o, 1'b0, 1'b1);
        img = put_lit(img, 1, 0, 0, 1'b0);
        img = put_lit(img, 2, 0, N_IN+1, 1'b0);
        img = put_lit(img, 0, 0, N_IN+1, 1'b0);
        img = put_lit(img, 3, 0, N_IN+2, 1'b1);
        load_map(img);
        for (int r = 0; r < 6; r++) begin
            logic [N_IN-1:0] v;
            v = N_IN'($urandom);
            run_cycle(v, "R9 feedback model");
            chk(seen_val[2] == v[0], "R9 lower comb feedback", 32'(seen_val[2]), 32'(v[0]));
            chk(seen_val[3] == !v[0], "R9 complemented feedback", 32'(seen_val[3]), 32'(!v[0]));
            chk(seen_val[0] == 1'b0, "R9 higher comb feedback blocked", 32'(seen_val[0]), 32'h0);
        end

        // random images against the model
        for (int n = 0; n < 6; n++) begin
            img = '0;
            for (int b = 0; b < AND_BITS; b++) img[b] = ($urandom % 24) == 0;
            for (int o = 0; o < N_OUT; o++) img = put_mode(img, o, 1'($urandom), 1'($urandom));
            load_map(img);
            for (int c = 0; c < 30; c++) run_cycle(N_IN'($urandom), "R4 R6 R7 R9 random image");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule